// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control sequencer a 16-bit processor core uses to enter an interrupt handler. At an instruction boundary, signalled by a one-cycle strobe from the core, it chooses one pending source. The sources are a non-maskable request, a software interrupt instruction with its own 8-bit type, and a level-sensitive maskable request. The chosen source gives the 8-bit interrupt type.

The sequencer then runs five word transfers on a simple request/ready memory port. It writes three words to the stack, then reads two words from the vector table. At the end it presents the new instruction pointer, code segment, stack pointer and flags to the core for one cycle, together with a completion pulse.

Stack words go to the physical address segment×16 + offset, with a 20-bit result. Vector words sit at type×4 (the instruction pointer) and type×4+2 (the code segment). The whole table therefore lies between 00000h and 003FFh.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a sequence, `mem_req`, `done` and `busy` are 0.
- R2: Three stack writes are made in this order: the flags word, then the code segment, then the instruction pointer. The stack pointer is lowered by 2 before each write, so the writes go to ss×16 + (sp−2), (sp−4) and (sp−6). `new_sp` equals sp−6.
- R3: The new instruction pointer is read from physical address type×4. The new code segment is read from type×4+2, directly after it. Both are returned on `new_ip` and `new_cs`, and every vector read address lies below 00400h.
- R4: `new_flags` is the flags snapshot with bit 9 (interrupt enable) and bit 8 (trap) cleared and every other bit kept. The pushed flags word is the unmodified snapshot.
- R5: A rising edge of `nmi_req` is latched and always wins, using type 2 (vectors at 00008h and 0000Ah). A request held high is taken only once per rising edge.
- R6: The software request wins over the maskable request and uses `swi_type`. The full type range 00h to FFh is honoured.
- R7: The maskable request is level-sensitive and uses `intr_type`. It is taken only when bit 9 of `flags_i` is 1. Otherwise no memory cycle occurs.
- R8: A sequence starts only on a `boundary_i` strobe while the block is idle. Requests without a strobe, and strobes during a sequence, start nothing.
- R9: While `mem_req` is high and `mem_ready` is low, address, write enable and write data hold steady. Each word is transferred in exactly one cycle in which both `mem_req` and `mem_ready` are high.
- R10: `done` is a single-cycle pulse in the cycle after the last vector read is accepted. The `new_*` outputs are valid in that cycle. `busy` is high from the first memory request up to and including `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| nmi_req | input | 1 | Non-maskable request, edge-latched |
| swi_req | input | 1 | Software interrupt instruction pending |
| swi_type | input | 8 | Type carried by the software interrupt |
| intr_req | input | 1 | Maskable request, level-sensitive |
| intr_type | input | 8 | Type supplied with the maskable request |
| flags_i | input | 16 | Current flags word |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, sampled when ready |
| mem_ready | input | 1 | Transfer accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete pulse |
| new_ip | output | 16 | Handler instruction pointer |
| new_cs | output | 16 | Handler code segment |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_flags | output | 16 | Flags with interrupt enable and trap cleared |

## Verification
The bench drives each source alone and in overlapping combinations. It uses distinct types, so priority and type selection show directly in the vector read addresses. The type extremes 00h and FFh check that vector addressing spans the whole table. A maskable request with interrupt enable clear, and flags with all bits set, separate gating from clearing. Wait states on the memory port and a held-high non-maskable request distinguish handshake hold and edge latching from plain level behaviour. Strobes missing or arriving mid-sequence confirm that only idle boundaries start work.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int WORD_W    = 16;
    localparam int TYPE_W    = 8;
    localparam int SEG_SHIFT = 4;
    localparam int PHYS_W    = WORD_W + SEG_SHIFT;
    localparam int IE_BIT    = 9;
    localparam int TRAP_BIT  = 8;
    localparam logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2);
    localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_RD_IP,
        ST_RD_CS,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] ss;
        logic [TYPE_W-1:0] vtype;
    } entry_ctx_t;

    function automatic logic [PHYS_W-1:0] seg_to_phys(input logic [WORD_W-1:0] seg,
                                                      input logic [WORD_W-1:0] off);
        return PHYS_W'({seg, {SEG_SHIFT{1'b0}}}) + PHYS_W'(off);
    endfunction

    function automatic logic [PHYS_W-1:0] vector_addr(input logic [TYPE_W-1:0] vt,
                                                      input logic seg_word);
        return PHYS_W'({vt, seg_word, 1'b0});
    endfunction

    function automatic logic [WORD_W-1:0] entry_flags(input logic [WORD_W-1:0] f);
        logic [WORD_W-1:0] r;
        r = f;
        r[IE_BIT]   = 1'b0;
        r[TRAP_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_req,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              intr_req,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              ie_flag,
    input  logic              take,
    output logic              grant_vld,
    output logic [TYPE_W-1:0] grant_type
);

    logic nmi_q;
    logic nmi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_req;
            if (take && nmi_pend)
                nmi_pend <= 1'b0;
            else if (nmi_req && !nmi_q)
                nmi_pend <= 1'b1;
        end
    end

    always_comb begin
        grant_vld  = nmi_pend || swi_req || (intr_req && ie_flag);
        if (nmi_pend)
            grant_type = NMI_TYPE;
        else if (swi_req)
            grant_type = swi_type;
        else
            grant_type = intr_type;
    end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              grant_vld,
    input  logic [TYPE_W-1:0] grant_type,
    input  logic [WORD_W-1:0] flags_i,
    input  logic [WORD_W-1:0] cs_i,
    input  logic [WORD_W-1:0] ip_i,
    input  logic [WORD_W-1:0] ss_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              take,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_sp,
    output logic [WORD_W-1:0] new_flags
);

    seq_state_t        state;
    entry_ctx_t        ctx;
    logic [WORD_W-1:0] sp_cur;
    logic [WORD_W-1:0] ip_q;
    logic [WORD_W-1:0] cs_q;
    logic              xfer;

    assign take = boundary_i && (state == ST_IDLE) && grant_vld;
    assign xfer = mem_req && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctx    <= '0;
            sp_cur <= '0;
            ip_q   <= '0;
            cs_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (take) begin
                    ctx.flags <= flags_i;
                    ctx.cs    <= cs_i;
                    ctx.ip    <= ip_i;
                    ctx.ss    <= ss_i;
                    ctx.vtype <= grant_type;
                    sp_cur    <= sp_i - WORD_STEP;
                    state     <= ST_PUSH_FL;
                end
                ST_PUSH_FL: if (xfer) begin
                    sp_cur <= sp_cur - WORD_STEP;
                    state  <= ST_PUSH_CS;
                end
                ST_PUSH_CS: if (xfer) begin
                    sp_cur <= sp_cur - WORD_STEP;
                    state  <= ST_PUSH_IP;
                end
                ST_PUSH_IP: if (xfer) state <= ST_RD_IP;
                ST_RD_IP: if (xfer) begin
                    ip_q  <= mem_rdata;
                    state <= ST_RD_CS;
                end
                ST_RD_CS: if (xfer) begin
                    cs_q  <= mem_rdata;
                    state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_FL: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr  = seg_to_phys(ctx.ss, sp_cur);
                mem_wdata = ctx.flags;
            end
            ST_PUSH_CS: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr  = seg_to_phys(ctx.ss, sp_cur);
                mem_wdata = ctx.cs;
            end
            ST_PUSH_IP: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr  = seg_to_phys(ctx.ss, sp_cur);
                mem_wdata = ctx.ip;
            end
            ST_RD_IP: begin
                mem_req  = 1'b1;
                mem_addr = vector_addr(ctx.vtype, 1'b0);
            end
            ST_RD_CS: begin
                mem_req  = 1'b1;
                mem_addr = vector_addr(ctx.vtype, 1'b1);
            end
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FIN);
    assign new_ip    = ip_q;
    assign new_cs    = cs_q;
    assign new_sp    = sp_cur;
    assign new_flags = entry_flags(ctx.flags);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              nmi_req,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              intr_req,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic [WORD_W-1:0] flags_i,
    input  logic [WORD_W-1:0] cs_i,
    input  logic [WORD_W-1:0] ip_i,
    input  logic [WORD_W-1:0] ss_i,
    input  logic [WORD_W-1:0] sp_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_sp,
    output logic [WORD_W-1:0] new_flags
);

    logic              take;
    logic              grant_vld;
    logic [TYPE_W-1:0] grant_type;

    irq_prio_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .nmi_req    (nmi_req),
        .swi_req    (swi_req),
        .swi_type   (swi_type),
        .intr_req   (intr_req),
        .intr_type  (intr_type),
        .ie_flag    (flags_i[IE_BIT]),
        .take       (take),
        .grant_vld  (grant_vld),
        .grant_type (grant_type)
    );

    irq_entry_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .grant_vld  (grant_vld),
        .grant_type (grant_type),
        .flags_i    (flags_i),
        .cs_i       (cs_i),
        .ip_i       (ip_i),
        .ss_i       (ss_i),
        .sp_i       (sp_i),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .take       (take),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done),
        .new_ip     (new_ip),
        .new_cs     (new_cs),
        .new_sp     (new_sp),
        .new_flags  (new_flags)
    );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_entry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [PHYS_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] new_flags
);

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr[PHYS_W-1:10] == '0)); // R3

    AST_SEG_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready && !mem_addr[1])
        |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + PHYS_W'(2))); // R3

    AST_ENTRY_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done |-> (!new_flags[IE_BIT] && !new_flags[TRAP_BIT])); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> busy); // R10

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R10

endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .new_flags (new_flags)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        boundary_i, nmi_req, swi_req, intr_req;
    logic [7:0]  swi_type, intr_type;
    logic [15:0] flags_i, cs_i, ip_i, ss_i, sp_i;
    logic        mem_req, mem_we, mem_ready;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] new_ip, new_cs, new_sp, new_flags;

    always #2.5 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .nmi_req(nmi_req),
        .swi_req(swi_req), .swi_type(swi_type), .intr_req(intr_req),
        .intr_type(intr_type), .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i),
        .ss_i(ss_i), .sp_i(sp_i), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .new_ip(new_ip),
        .new_cs(new_cs), .new_sp(new_sp), .new_flags(new_flags)
    );

    // memory model with programmable wait states and a transfer log
    logic [1:0]  wait_cfg;
    logic [1:0]  wcnt;
    logic        clr_log;
    int          nw, nr;
    logic [19:0] waddr [8];
    logic [15:0] wdat  [8];
    logic [19:0] raddr [8];

    assign mem_ready = mem_req && (wcnt >= wait_cfg);
    assign mem_rdata = mem_addr[15:0] * 16'd3 + 16'h1234;

    always_ff @(posedge clk) begin
        if (rst || clr_log) begin
            wcnt <= '0; nw <= 0; nr <= 0;
        end else if (mem_req) begin
            if (mem_ready) begin
                wcnt <= '0;
                if (mem_we) begin
                    waddr[nw[2:0]] <= mem_addr;
                    wdat[nw[2:0]]  <= mem_wdata;
                    nw <= nw + 1;
                end else begin
                    raddr[nr[2:0]] <= mem_addr;
                    nr <= nr + 1;
                end
            end else begin
                wcnt <= wcnt + 2'd1;
            end
        end
    end

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [15:0] rd_model(input logic [19:0] a);
        return a[15:0] * 16'd3 + 16'h1234;
    endfunction

    typedef struct packed {
        logic       nmi;
        logic       swi;
        logic       intr;
        logic [7:0] swi_t;
        logic [7:0] intr_t;
        logic [15:0] flags;
        logic [1:0] waits;
        logic       take;
        logic [7:0] etype;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'h21, 16'h0200, 2'd0, 1'b1, 8'h21}, // R7 maskable, IE=1
        '{1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 16'h0000, 2'd0, 1'b1, 8'hFF}, // R6 top of table
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0100, 2'd0, 1'b1, 8'h02}, // R5 nmi alone
        '{1'b1, 1'b1, 1'b1, 8'h33, 8'h44, 16'h0200, 2'd1, 1'b1, 8'h02}, // R5 nmi beats all
        '{1'b0, 1'b1, 1'b1, 8'h10, 8'h44, 16'h0200, 2'd0, 1'b1, 8'h10}, // R6 swi beats maskable
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'h55, 16'hFDFF, 2'd0, 1'b0, 8'h00}, // R7 IE=0 blocks
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 2'd2, 1'b1, 8'h00}, // R6 type 00, R9 waits
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 16'hFFFF, 2'd1, 1'b1, 8'h80}  // R4 all flags set
    };

    task automatic pulse_boundary();
        @(negedge clk); boundary_i = 1'b1;
        @(negedge clk); boundary_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int c = 0; c < 60; c++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        bit seen;
        logic [15:0] s_ss, s_sp, s_cs, s_ip, spk;
        logic [19:0] vb;
        s_ss = 16'h1000 + 16'(idx * 16'h0111);
        s_sp = 16'h0100 + 16'(idx * 16);
        s_cs = 16'hC000 + 16'(idx);
        s_ip = 16'h0400 + 16'(idx * 3);
        @(negedge clk);
        clr_log = 1'b1; wait_cfg = v.waits;
        ss_i = s_ss; sp_i = s_sp; cs_i = s_cs; ip_i = s_ip; flags_i = v.flags;
        swi_type = v.swi_t; intr_type = v.intr_t;
        @(negedge clk);
        clr_log = 1'b0;
        nmi_req = v.nmi; swi_req = v.swi; intr_req = v.intr;
        @(negedge clk); @(negedge clk);
        pulse_boundary();
        wait_done(seen);
        if (v.take) begin
            check(seen, "R10", "done seen", 32'(seen), 32'd1);
            check(nw == 3, "R2", "write count", 32'(nw), 32'd3);
            for (int k = 0; k < 3; k++) begin
                spk = s_sp - 16'(2 * (k + 1));
                check(waddr[k] == phys(s_ss, spk), "R2", "push addr",
                      32'(waddr[k]), 32'(phys(s_ss, spk)));
            end
            check(wdat[0] == v.flags, "R4", "pushed flags", 32'(wdat[0]), 32'(v.flags));
            check(wdat[1] == s_cs, "R2", "pushed cs", 32'(wdat[1]), 32'(s_cs));
            check(wdat[2] == s_ip, "R2", "pushed ip", 32'(wdat[2]), 32'(s_ip));
            vb = {10'd0, v.etype, 2'b00};
            check(nr == 2, "R3", "read count", 32'(nr), 32'd2);
            check(raddr[0] == vb, "R3", "ip vector addr (type select R5 R6 R7)",
                  32'(raddr[0]), 32'(vb));
            check(raddr[1] == vb + 20'd2, "R3", "cs vector addr",
                  32'(raddr[1]), 32'(vb + 20'd2));
            check(new_ip == rd_model(vb), "R3", "new_ip", 32'(new_ip), 32'(rd_model(vb)));
            check(new_cs == rd_model(vb + 20'd2), "R3", "new_cs",
                  32'(new_cs), 32'(rd_model(vb + 20'd2)));
            check(new_sp == s_sp - 16'd6, "R2", "new_sp", 32'(new_sp), 32'(s_sp - 16'd6));
            check(new_flags == (v.flags & 16'hFCFF), "R4", "new_flags",
                  32'(new_flags), 32'(v.flags & 16'hFCFF));
            @(negedge clk);
            check(!done && !busy, "R10", "done single pulse", 32'({done, busy}), 32'd0);
        end else begin
            check(!seen && nw == 0 && nr == 0 && !busy, "R7", "masked request ignored",
                  32'(nw + nr), 32'd0);
        end
        nmi_req = 1'b0; swi_req = 1'b0; intr_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit seen;
        rst = 1'b1; boundary_i = 0; nmi_req = 0; swi_req = 0; intr_req = 0;
        swi_type = 0; intr_type = 0; flags_i = 0; cs_i = 0; ip_i = 0;
        ss_i = 16'h2000; sp_i = 16'h0200; wait_cfg = 0; clr_log = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_req && !done && !busy, "R1", "reset state",
              32'({mem_req, done, busy}), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R8: requests without a strobe start nothing
        clr_log = 1'b1; @(negedge clk); clr_log = 1'b0;
        swi_req = 1'b1; swi_type = 8'h07; flags_i = 16'h0200; intr_req = 1'b1;
        repeat (10) @(negedge clk);
        check(nw == 0 && nr == 0 && !busy, "R8", "no start without boundary",
              32'(nw + nr), 32'd0);

        // R8: boundary during a sequence is ignored
        wait_cfg = 2'd1;
        pulse_boundary();
        @(negedge clk);
        boundary_i = 1'b1; @(negedge clk); boundary_i = 1'b0;
        wait_done(seen);
        swi_req = 1'b0; intr_req = 1'b0;
        repeat (10) @(negedge clk);
        check(nw == 3 && nr == 2 && !busy, "R8", "mid-sequence strobe ignored",
              32'(nw * 16 + nr), 32'h32);

        // R5: held-high nmi is taken once per rising edge
        clr_log = 1'b1; wait_cfg = 0; @(negedge clk); clr_log = 1'b0;
        nmi_req = 1'b1; repeat (2) @(negedge clk);
        pulse_boundary();
        wait_done(seen);
        check(seen && raddr[0] == 20'h00008, "R5", "nmi vector",
              32'(raddr[0]), 32'h8);
        @(negedge clk);
        clr_log = 1'b1; @(negedge clk); clr_log = 1'b0;
        pulse_boundary();
        repeat (10) @(negedge clk);
        check(nw == 0 && !busy, "R5", "level nmi not retaken", 32'(nw), 32'd0);
        nmi_req = 1'b0; @(negedge clk);

        // R1: reset in mid-sequence
        swi_req = 1'b1; swi_type = 8'h40; wait_cfg = 2'd3;
        pulse_boundary();
        @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0; swi_req = 1'b0;
        @(negedge clk);
        check(!mem_req && !busy && !done, "R1", "mid-sequence reset",
              32'({mem_req, busy, done}), 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule